// File: doc/BRIEF.md
# Single-Channel Block Transfer Engine

This block copies a programmed number of words without processor involvement. It can move words from a peripheral into memory, from memory out to a peripheral, or from one memory region to another. Software writes a start address, an optional destination address and a word count. It then writes a control word that selects the direction, how the bus is used and how each word is carried, and that arms the channel.

The engine waits until the peripheral signals that it has a word ready. It then requests the shared bus from an arbiter and performs memory accesses only while the grant is present. Each word moved to or from the peripheral is acknowledged with a one-cycle pulse. In flyby mode a word crosses between the peripheral and memory in a single bus cycle. In fetch-and-deposit mode the word is first loaded into an internal holding register and written out in a later cycle; this mode also performs memory-to-memory copies. When the count runs out, the engine raises a level interrupt and goes back to idle. Software clears the interrupt by writing a one to the done flag.

Top module: `dma_engine`

## Requirements
- R1: After synchronous reset, `irq`, `bus_req`, `per_ack` and `mem_en` are 0, and reads of the status register (index 4) and count register (index 3) return 0.
- R2: Register indices are 0 control, 1 source/memory address, 2 destination address, 3 count, 4 status. The address increments by one and the count decrements by one for every word moved. After a transfer of N words from address A, index 1 reads A+N and index 3 reads 0.
- R3: With control bit 1 set (memory to peripheral), the word read from memory at address A+k is presented on `per_wdata` in the cycle in which `per_ack` pulses for word k. With bit 1 clear, `per_rdata` of word k is stored at memory address A+k.
- R4: `per_ack` pulses exactly once per word in peripheral transfers, and never in memory-to-memory copies.
- R5: With control bit 2 clear (cycle stealing), `bus_req` drops for at least one cycle after every word, so it rises once per word.
- R6: With control bit 2 set (burst), `bus_req` rises once and stays high until the last word is done.
- R7: `bus_req` rises only after `per_req` was high (or in a memory-to-memory copy). No memory access happens without `bus_gnt`.
- R8: With control bit 3 clear (flyby), each word takes one bus cycle. With bit 3 set (fetch-and-deposit), each word takes two bus cycles: a fetch into the holding register, then a deposit.
- R9: With control bit 4 set, the engine copies N words from memory at the source address to the destination address using fetch-and-deposit, and index 2 ends at destination+N.
- R10: After the last word, status bit 1 (done) and `irq` go high and status bit 0 (busy) goes low. Writing 1 to status bit 1 clears done and `irq`.
- R11: A start (control bit 0 written as 1) with a count of 0 sets done on the next cycle and never asserts `bus_req`.
- R12: While busy, writes to the control, address and count registers are ignored, including a new start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register index |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Read data of the selected register |
| per_req | input | 1 | Peripheral has a word ready |
| per_ack | output | 1 | One-cycle acknowledge per peripheral word |
| per_rdata | input | DW | Word from peripheral |
| per_wdata | output | DW | Word to peripheral |
| bus_req | output | 1 | Bus request to arbiter |
| bus_gnt | input | 1 | Bus grant from arbiter |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, valid in the access cycle |
| irq | output | 1 | Completion interrupt (level) |

## Verification
A sequencer stuck in the wrong state shows at once on `bus_req`: the number of request cycles per block differs from what the selected mode implies, and a missing release shows as too few rising edges within the first two words. A wrong holding-register or address path puts the wrong value into the first or second memory word, or onto the acknowledged peripheral data, so each transfer is checked word by word. A register state that has drifted out of step shows up in the address and count readback when the interrupt rises.

// File: rtl/dma_pkg.sv
package dma_pkg;

    localparam logic [2:0] IDX_CTRL  = 3'd0;
    localparam logic [2:0] IDX_ADDR  = 3'd1;
    localparam logic [2:0] IDX_DEST  = 3'd2;
    localparam logic [2:0] IDX_COUNT = 3'd3;
    localparam logic [2:0] IDX_STAT  = 3'd4;

    // mode bits as written in control bits [4:1]
    typedef struct packed {
        logic m2m;
        logic fd;
        logic burst;
        logic to_per;
    } dma_cfg_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_ARB,
        ST_MOVE,
        ST_PUT,
        ST_HOLD
    } dma_state_t;

    function automatic logic uses_hold(dma_cfg_t c);
        return c.fd | c.m2m;
    endfunction

    function automatic logic src_ready(dma_cfg_t c, logic req);
        return req | c.m2m;
    endfunction

endpackage

// File: rtl/dma_regs.sv
module dma_regs
    import dma_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_wr,
    input  logic [2:0]    reg_sel,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic          busy,
    input  logic          src_inc,
    input  logic          dst_inc,
    input  logic          cnt_dec,
    input  logic          set_done,
    output logic          go,
    output dma_cfg_t      cfg,
    output logic [AW-1:0] src_addr,
    output logic [AW-1:0] dst_addr,
    output logic          cnt_zero,
    output logic          cnt_one,
    output logic          done
);
    logic [CW-1:0] cnt_q;
    logic          wr_ok;
    logic          clr_done;

    assign wr_ok    = reg_wr && !busy;
    assign go       = wr_ok && (reg_sel == IDX_CTRL) && reg_wdata[0];
    assign clr_done = reg_wr && (reg_sel == IDX_STAT) && reg_wdata[1];
    assign cnt_zero = (cnt_q == '0);
    assign cnt_one  = (cnt_q == CW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg      <= '0;
            src_addr <= '0;
            dst_addr <= '0;
            cnt_q    <= '0;
            done     <= 1'b0;
        end else begin
            if (wr_ok && reg_sel == IDX_CTRL)
                cfg <= dma_cfg_t'(reg_wdata[4:1]);
            if (src_inc)
                src_addr <= src_addr + AW'(1);
            else if (wr_ok && reg_sel == IDX_ADDR)
                src_addr <= reg_wdata[AW-1:0];
            if (dst_inc)
                dst_addr <= dst_addr + AW'(1);
            else if (wr_ok && reg_sel == IDX_DEST)
                dst_addr <= reg_wdata[AW-1:0];
            if (cnt_dec)
                cnt_q <= cnt_q - CW'(1);
            else if (wr_ok && reg_sel == IDX_COUNT)
                cnt_q <= reg_wdata[CW-1:0];
            if (set_done)
                done <= 1'b1;
            else if (clr_done)
                done <= 1'b0;
        end
    end

    always_comb begin
        case (reg_sel)
            IDX_CTRL:  reg_rdata = DW'({cfg, 1'b0});
            IDX_ADDR:  reg_rdata = DW'(src_addr);
            IDX_DEST:  reg_rdata = DW'(dst_addr);
            IDX_COUNT: reg_rdata = DW'(cnt_q);
            IDX_STAT:  reg_rdata = DW'({done, busy});
            default:   reg_rdata = '0;
        endcase
    end

    // R12: a busy channel keeps its count except for its own decrements
    p_busy_holds_count_r12: assert property (@(posedge clk) disable iff (rst)
        busy && !cnt_dec |=> cnt_q == $past(cnt_q));

    // R10: done only rises once the count has run out
    p_done_at_zero_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> cnt_zero);

    // R10: write-one-to-clear takes effect unless a completion coincides
    p_w1c_clears_r10: assert property (@(posedge clk) disable iff (rst)
        clr_done && !set_done |=> !done);

endmodule

// File: rtl/dma_ctrl.sv
module dma_ctrl
    import dma_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     go,
    input  dma_cfg_t cfg,
    input  logic     cnt_zero,
    input  logic     cnt_one,
    input  logic     per_req,
    input  logic     bus_gnt,
    output logic     busy,
    output logic     bus_req,
    output logic     per_ack,
    output logic     mem_en,
    output logic     mem_we,
    output logic     use_dst,
    output logic     hold_load,
    output logic     hold_from_per,
    output logic     src_inc,
    output logic     dst_inc,
    output logic     cnt_dec,
    output logic     set_done
);
    dma_state_t st, st_nx;
    logic       fd;
    logic       ready;
    logic       word_done;
    logic       in_move, in_put;

    assign fd        = uses_hold(cfg);
    assign ready     = src_ready(cfg, per_req);
    assign in_move   = (st == ST_MOVE);
    assign in_put    = (st == ST_PUT);
    assign word_done = (in_move && !fd) || in_put;

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE: if (go && !cnt_zero) st_nx = ST_WAIT;
            ST_WAIT: if (ready) st_nx = ST_ARB;
            ST_ARB:  if (bus_gnt) st_nx = ST_MOVE;
            ST_HOLD: if (ready) st_nx = ST_MOVE;
            ST_MOVE, ST_PUT: begin
                if (in_move && fd)
                    st_nx = ST_PUT;
                else if (cnt_one)
                    st_nx = ST_IDLE;
                else if (cfg.burst)
                    st_nx = ready ? ST_MOVE : ST_HOLD;
                else
                    st_nx = ST_WAIT;
            end
            default: st_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st <= ST_IDLE;
        else     st <= st_nx;
    end

    assign busy    = (st != ST_IDLE);
    assign bus_req = (st == ST_ARB) || in_move || in_put || (st == ST_HOLD);

    always_comb begin
        if (!fd) begin
            per_ack = in_move;
            mem_en  = in_move;
            mem_we  = in_move && !cfg.to_per;
        end else begin
            per_ack = !cfg.m2m && (cfg.to_per ? in_put : in_move);
            mem_en  = (in_move && (cfg.to_per || cfg.m2m)) ||
                      (in_put && (!cfg.to_per || cfg.m2m));
            mem_we  = in_put;
        end
    end

    assign use_dst       = cfg.m2m && in_put;
    assign hold_load     = in_move && fd;
    assign hold_from_per = !cfg.to_per && !cfg.m2m;
    assign src_inc       = word_done;
    assign dst_inc       = word_done && cfg.m2m;
    assign cnt_dec       = word_done;
    assign set_done      = (st == ST_IDLE && go && cnt_zero) || (word_done && cnt_one);

    // R5: cycle stealing releases the bus after every word
    p_steal_release_r5: assert property (@(posedge clk) disable iff (rst)
        word_done && !cfg.burst |=> !bus_req);

    // R6: burst keeps the bus until the final word
    p_burst_keeps_bus_r6: assert property (@(posedge clk) disable iff (rst)
        cfg.burst && bus_req && !(word_done && cnt_one) |=> bus_req);

    // R7: a new bus request follows a ready source
    p_req_after_ready_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_req) |-> ($past(per_req) || cfg.m2m));

    // R7: memory is only touched with the grant present
    p_access_granted_r7: assert property (@(posedge clk) disable iff (rst)
        mem_en |-> bus_gnt);

    // R4: acknowledges belong to peripheral transfers on an owned bus
    p_ack_periph_only_r4: assert property (@(posedge clk) disable iff (rst)
        per_ack |-> (!cfg.m2m && bus_req));

    // R11: an empty start never leaves idle
    p_zero_count_idle_r11: assert property (@(posedge clk) disable iff (rst)
        !busy && go && cnt_zero |=> !busy && !bus_req);

endmodule

// File: rtl/dma_dpath.sv
module dma_dpath #(
    parameter int DW = 32,
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fd,
    input  logic          hold_load,
    input  logic          hold_from_per,
    input  logic          use_dst,
    input  logic [AW-1:0] src_addr,
    input  logic [AW-1:0] dst_addr,
    input  logic [DW-1:0] per_rdata,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic [DW-1:0] per_wdata
);
    logic [DW-1:0] hold_q;

    always_ff @(posedge clk) begin
        if (rst)
            hold_q <= '0;
        else if (hold_load)
            hold_q <= hold_from_per ? per_rdata : mem_rdata;
    end

    assign mem_addr  = use_dst ? dst_addr : src_addr;
    assign mem_wdata = fd ? hold_q : per_rdata;
    assign per_wdata = fd ? hold_q : mem_rdata;

endmodule

// File: rtl/dma_engine.sv
module dma_engine
    import dma_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_wr,
    input  logic [2:0]    reg_sel,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic          per_req,
    output logic          per_ack,
    input  logic [DW-1:0] per_rdata,
    output logic [DW-1:0] per_wdata,
    output logic          bus_req,
    input  logic          bus_gnt,
    output logic          mem_en,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic          irq
);
    dma_cfg_t      cfg;
    logic          go, busy, done;
    logic          cnt_zero, cnt_one;
    logic          src_inc, dst_inc, cnt_dec, set_done;
    logic          use_dst, hold_load, hold_from_per;
    logic [AW-1:0] src_addr, dst_addr;

    dma_regs #(.DW(DW), .AW(AW), .CW(CW)) u_regs (
        .clk(clk), .rst(rst),
        .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .busy(busy), .src_inc(src_inc), .dst_inc(dst_inc), .cnt_dec(cnt_dec),
        .set_done(set_done), .go(go), .cfg(cfg),
        .src_addr(src_addr), .dst_addr(dst_addr),
        .cnt_zero(cnt_zero), .cnt_one(cnt_one), .done(done)
    );

    dma_ctrl u_ctrl (
        .clk(clk), .rst(rst), .go(go), .cfg(cfg),
        .cnt_zero(cnt_zero), .cnt_one(cnt_one),
        .per_req(per_req), .bus_gnt(bus_gnt),
        .busy(busy), .bus_req(bus_req), .per_ack(per_ack),
        .mem_en(mem_en), .mem_we(mem_we), .use_dst(use_dst),
        .hold_load(hold_load), .hold_from_per(hold_from_per),
        .src_inc(src_inc), .dst_inc(dst_inc), .cnt_dec(cnt_dec), .set_done(set_done)
    );

    dma_dpath #(.DW(DW), .AW(AW)) u_dpath (
        .clk(clk), .rst(rst), .fd(uses_hold(cfg)),
        .hold_load(hold_load), .hold_from_per(hold_from_per), .use_dst(use_dst),
        .src_addr(src_addr), .dst_addr(dst_addr),
        .per_rdata(per_rdata), .mem_rdata(mem_rdata),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .per_wdata(per_wdata)
    );

    assign irq = done;

    // R10: interrupt and busy are never high together after completion
    p_irq_after_idle_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> !busy);

endmodule

// File: tb/dma_engine_tb.sv
module dma_engine_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_sel = 3'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        per_req = 1'b0;
    logic        per_ack;
    logic [31:0] per_rdata;
    logic [31:0] per_wdata;
    logic        bus_req;
    logic        bus_gnt;
    logic        mem_en, mem_we;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        irq;

    always #5 clk = ~clk;

    dma_engine u_dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .per_req(per_req), .per_ack(per_ack), .per_rdata(per_rdata), .per_wdata(per_wdata),
        .bus_req(bus_req), .bus_gnt(bus_gnt),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .irq(irq)
    );

    // environment: memory, arbiter with one-cycle grant latency, peripheral
    logic [31:0] mem [0:63];
    logic [31:0] cap [0:63];
    logic [31:0] per_seq;
    logic        fresh = 1'b0;
    logic        breq_d;
    int          n_ack, n_rise, n_bcyc;

    assign mem_rdata = mem[mem_addr[5:0]];
    assign per_rdata = 32'h3C00_0000 | per_seq;

    always @(posedge clk) begin
        if (rst) bus_gnt <= 1'b0;
        else     bus_gnt <= bus_req;
        if (fresh) begin
            for (int i = 0; i < 64; i++) mem[i] <= 32'hA500_0000 | i;
            per_seq <= '0;
            n_ack <= 0; n_rise <= 0; n_bcyc <= 0;
            breq_d <= 1'b0;
        end else begin
            if (mem_en && mem_we) mem[mem_addr[5:0]] <= mem_wdata;
            if (per_ack) begin
                cap[per_seq[5:0]] <= per_wdata;
                per_seq <= per_seq + 1;
                n_ack <= n_ack + 1;
            end
            if (bus_req) n_bcyc <= n_bcyc + 1;
            if (bus_req && !breq_d) n_rise <= n_rise + 1;
            breq_d <= bus_req;
        end
    end

    int checks = 0;
    int fails  = 0;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] sel, output logic [31:0] d);
        @(negedge clk);
        reg_sel = sel;
        #1 d = reg_rdata;
    endtask

    task automatic clean();
        @(negedge clk); fresh = 1'b1;
        @(negedge clk); fresh = 1'b0;
    endtask

    task automatic wait_irq();
        for (int i = 0; i < 400 && !irq; i++) @(negedge clk);
    endtask

    // {m2m, fd, burst, to_per, count[8], src[8], dst[8]}
    localparam logic [27:0] VEC [0:7] = '{
        {4'b0000, 8'd4, 8'd8,  8'd0},
        {4'b0010, 8'd5, 8'd20, 8'd0},
        {4'b0001, 8'd3, 8'd4,  8'd0},
        {4'b0011, 8'd6, 8'd30, 8'd0},
        {4'b0110, 8'd3, 8'd40, 8'd0},
        {4'b0101, 8'd4, 8'd12, 8'd0},
        {4'b1010, 8'd5, 8'd2,  8'd50},
        {4'b1000, 8'd1, 8'd60, 8'd0}
    };

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        clean();
        // R1 reset state
        check(irq == 1'b0 && bus_req == 1'b0, "R1 irq/bus_req", {30'd0, irq, bus_req}, 32'd0);
        check(per_ack == 1'b0 && mem_en == 1'b0, "R1 ack/mem_en", {30'd0, per_ack, mem_en}, 32'd0);
        rd(3'd4, d); check(d == 32'd0, "R1 status", d, 32'd0);
        rd(3'd3, d); check(d == 32'd0, "R1 count", d, 32'd0);

        per_req = 1'b1;
        for (int v = 0; v < 8; v++) begin
            logic [3:0] md;
            int n, src, dst, bad, exp_cyc;
            logic [31:0] got, want;
            md  = VEC[v][27:24];
            n   = int'(VEC[v][23:16]);
            src = int'(VEC[v][15:8]);
            dst = int'(VEC[v][7:0]);
            wr(3'd4, 32'h2);
            clean();
            wr(3'd1, src); wr(3'd2, dst); wr(3'd3, n);
            wr(3'd0, {27'd0, md, 1'b1});
            wait_irq();
            @(negedge clk);
            rd(3'd4, d);
            check(irq && d == 32'h2, "R10 done set busy clear", d, 32'h2);
            rd(3'd3, d); check(d == 32'd0, "R2 final count", d, 32'd0);
            rd(3'd1, d); check(d == src + n, "R2 final address", d, src + n);
            bad = 0; got = '0; want = '0;
            for (int k = 0; k < n; k++) begin
                logic [31:0] a, e;
                if (md[3])      begin a = mem[(dst + k) % 64]; e = 32'hA500_0000 | (src + k); end
                else if (md[0]) begin a = cap[k];              e = 32'hA500_0000 | (src + k); end
                else            begin a = mem[(src + k) % 64]; e = 32'h3C00_0000 | k;         end
                if (a !== e && bad == 0) begin got = a; want = e; end
                if (a !== e) bad++;
            end
            if (md[3]) begin
                check(bad == 0, "R9 copied words", got, want);
                rd(3'd2, d); check(d == dst + n, "R9 final destination", d, dst + n);
            end else begin
                check(bad == 0, "R3 transferred words", got, want);
            end
            check(n_ack == (md[3] ? 0 : n), "R4 acknowledge count", n_ack, md[3] ? 0 : n);
            if (md[1]) check(n_rise == 1, "R6 burst single request", n_rise, 1);
            else       check(n_rise == n, "R5 request per word", n_rise, n);
            if (md[2] || md[3]) exp_cyc = md[1] ? 2 + 2 * n : 4 * n;
            else                exp_cyc = md[1] ? 2 + n : 3 * n;
            check(n_bcyc == exp_cyc, "R8 bus cycles for mode", n_bcyc, exp_cyc);
        end

        // R10 write-one-to-clear
        wr(3'd4, 32'h2);
        rd(3'd4, d);
        check(irq == 1'b0 && d == 32'd0, "R10 clear done", d, 32'd0);

        // R11 zero count
        clean();
        wr(3'd3, 32'd0);
        wr(3'd0, 32'h1);
        rd(3'd4, d);
        check(d == 32'h2 && irq, "R11 immediate done", d, 32'h2);
        repeat (4) @(negedge clk);
        check(n_rise == 0, "R11 no bus request", n_rise, 0);
        wr(3'd4, 32'h2);

        // R7 and R12: peripheral not ready, writes while busy
        per_req = 1'b0;
        clean();
        wr(3'd1, 32'd0); wr(3'd3, 32'd2);
        wr(3'd0, 32'h1);
        repeat (5) @(negedge clk);
        check(bus_req == 1'b0 && n_rise == 0, "R7 no request before ready", n_rise, 0);
        rd(3'd4, d); check(d == 32'h1, "R12 busy flag", d, 32'h1);
        wr(3'd3, 32'd9);
        wr(3'd0, 32'h5);
        rd(3'd3, d); check(d == 32'd2, "R12 count write ignored", d, 32'd2);
        rd(3'd0, d); check(d == 32'd0, "R12 control write ignored", d, 32'd0);
        per_req = 1'b1;
        wait_irq();
        @(negedge clk);
        check(n_ack == 2 && n_rise == 2, "R12 original transfer kept", n_rise, 2);
        check(mem[1] == 32'h3C00_0001, "R3 second word after stall", mem[1], 32'h3C00_0001);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule